// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI bus master that a processor drives through a small file of 8-bit registers on a simple single-cycle bus. Software sets the clock mode and bit order in a control register and the bit-clock rate in a rate register. A write to the data register then starts one 8-bit exchange. The received byte replaces the data register contents, a completion flag is raised, and an interrupt line follows the flag when interrupts are enabled.

Two faults are detected. A data write made while a byte is still shifting is dropped and flagged as a collision. When the slave-select pin is configured as an input and another master pulls it low, a mode fault is flagged: the block gives up master mode and raises a second interrupt line. The slave-select output is driven from a general port data bit under software control.

The register bus has no back-pressure. Every access completes in the cycle `bus_sel` is high, and read data is returned combinationally in that same cycle. The serial interface is plain pins, with no flow control beyond the completion flag.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0x00, `sck` is low, `ss_n` is high and both interrupt lines are low.
- R2: When the enable bit (control-1 bit 6) and the master bit (bit 4) are set, a write to the data register (offset 0x09) while idle starts an exchange. The byte is shifted out on `mosi`, LSB first when control-1 bit 0 is 1 and MSB first otherwise. The 8 bits sampled from `miso` are assembled in the same order and become the value read from the data register.
- R3: While idle, `sck` rests at the polarity bit (control-1 bit 3). An exchange makes 16 `sck` transitions. With the phase bit (control-1 bit 2) at 0, data is sampled on the first transition of each bit. With it at 1, data is sampled on the second transition.
- R4: The rate register (offset 0x04) holds a prescaler P in bits [6:4] and an exponent E in bits [2:0]; its other bits read 0. One `sck` period lasts (P+1)·2^(E+1) clocks. The completion flag sets 16·(P+1)·2^E + 1 clocks after the cycle of the data write.
- R5: On completion, status (offset 0x05) bit 7 sets. `irq_xfer` is high while that flag and the interrupt-enable bit (control-1 bit 7) are both set.
- R6: Completion and collision flags clear only when status is read while they are set and the data register is then read or written. A data access without that prior status read leaves them set.
- R7: A data write during an exchange is discarded: the byte already being shifted continues unchanged, and status bit 6 sets.
- R8: A mode fault occurs when the block is enabled and in master mode, port direction bit 3 (offset 0x10) is 0 and `ss_in_n` is low. It sets status bit 4, clears the master bit, raises `irq_modf` (gated by control-1 bit 7), and data writes then start nothing.
- R9: The mode-fault flag clears only when a status read that sees it set is followed by a write to control-1 (offset 0x00).
- R10: With port direction bit 3 set, `ss_n` follows port data bit 3 (offset 0x0D); writing 1 there raises it. With direction bit 3 clear, `ss_n` is high.
- R11: Clearing the enable bit aborts any exchange, returns `sck` to the polarity level and clears all status flags.
- R12: Control-2 (offset 0x01), port data and port direction read back what was written. Control-1 bit 5 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| miso | input | 1 | Serial data from the slave |
| ss_in_n | input | 1 | Slave-select pin level as seen at the pad |
| sck | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Slave-select output |
| irq_xfer | output | 1 | Byte-complete interrupt |
| irq_modf | output | 1 | Mode-fault interrupt |

## Verification
The bench sweeps all eight combinations of polarity, phase and bit order, and walks the rate exponent and the prescaler across their full ranges. A bench-side slave model checks each bit on `mosi` and drives `miso`. A phase error would show up as a received byte shifted by one bit or with its first bit lost. A wrong rate decode would show up as a completion time off by a factor of two or by one prescaler step. Targeted sequences cover the following cases:
- A data read without a preceding status read, which must leave the flag set.
- A collision write, which must neither restart the shift nor corrupt the byte on the wire.
- A mode fault, which must drop master mode and survive a control write until status has been read.
- A mid-exchange disable, which must park the clock and wipe the flags.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTRL1 = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CTRL2 = 5'h01;
  localparam logic [ADDR_W-1:0] OFF_RATE  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h05;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 5'h09;
  localparam logic [ADDR_W-1:0] OFF_PDAT  = 5'h0D;
  localparam logic [ADDR_W-1:0] OFF_PDIR  = 5'h10;

  // control-1 field positions
  localparam int C1_IE   = 7;
  localparam int C1_EN   = 6;
  localparam int C1_MSTR = 4;
  localparam int C1_POL  = 3;
  localparam int C1_PHA  = 2;
  localparam int C1_LSB  = 0;
  localparam logic [7:0] C1_MASK = 8'hDF;

  // status field positions
  localparam int ST_DONE = 7;
  localparam int ST_COLL = 6;
  localparam int ST_FLT  = 4;

  localparam int RATE_PRE_LSB = 4;
  localparam logic [7:0] RATE_MASK = 8'h77;
  localparam int SS_PIN = 3;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int CNT_W = PRE_W + (1 << EXP_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  // half period = (pre+1) << expo clocks
  assign half = (CNT_W'(pre) + CNT_W'(1)) << expo;
  assign tick = run && (cnt >= half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [EDGE_W-1:0] edge_idx;
  logic              sample_now;

  // even edges are leading edges of a bit; phase selects which one samples
  assign sample_now = (edge_idx[0] == cpha);
  assign mosi       = lsb_first ? tx_sr[0] : tx_sr[DATA_W-1];
  assign rx_byte    = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      done     <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      edge_idx <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy     <= 1'b0;
        sck      <= cpol;
        edge_idx <= '0;
      end else if (!busy) begin
        sck      <= cpol;
        edge_idx <= '0;
        if (start) begin
          busy  <= 1'b1;
          tx_sr <= tx_byte;
        end
      end else if (tick) begin
        sck      <= ~sck;
        edge_idx <= edge_idx + 1'b1;
        if (sample_now)
          rx_sr <= lsb_first ? {miso, rx_sr[DATA_W-1:1]} : {rx_sr[DATA_W-2:0], miso};
        else if (edge_idx != '0)
          tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        if (edge_idx == LAST_EDGE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int EXP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              miso,
  input  logic              ss_in_n,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              irq_xfer,
  output logic              irq_modf
);
  logic [7:0] ctrl1, ctrl2, rate, pdat, pdir, dreg, stat;
  logic       spif, wcol, modf;
  logic       spif_arm, wcol_arm, modf_arm;
  logic       spe, mstr, cpol, cpha, lsbf, spie;
  logic       rd, wr, c1_wr, st_rd, dat_wr, dat_acc, modf_hit;
  logic       xfer_busy, xfer_done, rate_tick;
  logic [7:0] rx_byte;

  assign spie = ctrl1[C1_IE];
  assign spe  = ctrl1[C1_EN];
  assign mstr = ctrl1[C1_MSTR];
  assign cpol = ctrl1[C1_POL];
  assign cpha = ctrl1[C1_PHA];
  assign lsbf = ctrl1[C1_LSB];

  assign rd      = bus_sel && !bus_wr;
  assign wr      = bus_sel && bus_wr;
  assign c1_wr   = wr && (bus_addr == OFF_CTRL1);
  assign st_rd   = rd && (bus_addr == OFF_STAT);
  assign dat_wr  = wr && (bus_addr == OFF_DATA);
  assign dat_acc = bus_sel && (bus_addr == OFF_DATA);

  assign modf_hit = spe && mstr && !pdir[SS_PIN] && !ss_in_n;

  spi_rate_div #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (xfer_busy),
    .pre  (rate[RATE_PRE_LSB +: PRE_W]),
    .expo (rate[0 +: EXP_W]),
    .tick (rate_tick)
  );

  spi_shift_engine #(.DATA_W(8)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dat_wr && spe && mstr),
    .abort    (!(spe && mstr)),
    .tick     (rate_tick),
    .cpol     (cpol),
    .cpha     (cpha),
    .lsb_first(lsbf),
    .miso     (miso),
    .tx_byte  (bus_wdata),
    .busy     (xfer_busy),
    .sck      (sck),
    .mosi     (mosi),
    .done     (xfer_done),
    .rx_byte  (rx_byte)
  );

  // plain registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1 <= '0;
      ctrl2 <= '0;
      rate  <= '0;
      pdat  <= '0;
      pdir  <= '0;
      dreg  <= '0;
    end else begin
      if (c1_wr)         ctrl1 <= bus_wdata & C1_MASK;
      else if (modf_hit) ctrl1[C1_MSTR] <= 1'b0;
      if (wr && bus_addr == OFF_CTRL2) ctrl2 <= bus_wdata;
      if (wr && bus_addr == OFF_RATE)  rate  <= bus_wdata & RATE_MASK;
      if (wr && bus_addr == OFF_PDAT)  pdat  <= bus_wdata;
      if (wr && bus_addr == OFF_PDIR)  pdir  <= bus_wdata;
      if (xfer_done) dreg <= rx_byte;
    end
  end

  // status flags with read-status-then-access clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {spif, wcol, modf}             <= '0;
      {spif_arm, wcol_arm, modf_arm} <= '0;
    end else if (!spe) begin
      {spif, wcol, modf}             <= '0;
      {spif_arm, wcol_arm, modf_arm} <= '0;
    end else begin
      if (st_rd) begin
        spif_arm <= spif;
        wcol_arm <= wcol;
        modf_arm <= modf;
      end else begin
        if (dat_acc) begin
          spif_arm <= 1'b0;
          wcol_arm <= 1'b0;
        end
        if (c1_wr) modf_arm <= 1'b0;
      end
      if (xfer_done)                spif <= 1'b1;
      else if (dat_acc && spif_arm) spif <= 1'b0;
      if (dat_wr && xfer_busy)      wcol <= 1'b1;
      else if (dat_acc && wcol_arm) wcol <= 1'b0;
      if (modf_hit)                 modf <= 1'b1;
      else if (c1_wr && modf_arm)   modf <= 1'b0;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_DONE] = spif;
    stat[ST_COLL] = wcol;
    stat[ST_FLT]  = modf;
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL1: bus_rdata = ctrl1;
      OFF_CTRL2: bus_rdata = ctrl2;
      OFF_RATE:  bus_rdata = rate;
      OFF_STAT:  bus_rdata = stat;
      OFF_DATA:  bus_rdata = dreg;
      OFF_PDAT:  bus_rdata = pdat;
      OFF_PDIR:  bus_rdata = pdir;
      default:   bus_rdata = '0;
    endcase
  end

  assign ss_n     = pdir[SS_PIN] ? pdat[SS_PIN] : 1'b1;
  assign irq_xfer = spie && spif;
  assign irq_modf = spie && modf;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic spe,
  input logic mstr,
  input logic cpol,
  input logic busy,
  input logic sck,
  input logic tick,
  input logic done,
  input logic spif,
  input logic wcol,
  input logic modf
);
  // R5: the completion flag only rises right after the shifter reports done
  a_r5_flag_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(done));

  // R4: the shifter finishes only on a rate-divider tick
  a_r4_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick));

  // R3: idle clock level equals polarity
  a_r3_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol));

  // R8: a mode fault drops master mode
  a_r8_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !mstr);

  // R11: disabling clears the shifter and every flag
  a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !spe |=> (!busy && !spif && !wcol && !modf));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .spe  (spe),
  .mstr (mstr),
  .cpol (cpol),
  .busy (xfer_busy),
  .sck  (sck),
  .tick (rate_tick),
  .done (xfer_done),
  .spif (spif),
  .wcol (wcol),
  .modf (modf)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  import spi_master_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic miso = 1'b0, ss_in_n = 1'b1;
  logic sck, mosi, ss_n, irq_xfer, irq_modf;

  int n_checks = 0, n_err = 0;

  // slave model state
  bit s_on = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0;
  logic [7:0] s_reply = '0, s_cap = '0;
  int edge_n = 0;

  always #5 clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .miso(miso), .ss_in_n(ss_in_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
    .irq_xfer(irq_xfer), .irq_modf(irq_modf)
  );

  function automatic int ord(input int i, input bit lsb);
    return lsb ? i : 7 - i;
  endfunction

  always @(sck) begin
    int n;
    if (s_on) begin
      n = edge_n;
      edge_n = edge_n + 1;
      #1;
      if ((n % 2) == int'(s_cpha)) begin
        if (n / 2 < 8) s_cap[ord(n / 2, s_lsb)] = mosi;
      end else if (s_cpha) begin
        miso = s_reply[ord(n / 2, s_lsb)];
      end else if ((n + 1) / 2 < 8) begin
        miso = s_reply[ord((n + 1) / 2, s_lsb)];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 1'b0;
  endtask

  task automatic do_xfer(input bit cp, input bit ch, input bit lb, input int pre, input int ex,
                         input logic [7:0] tx, input logic [7:0] rp, input bit collide);
    int half, cnt;
    logic [7:0] d;
    half = (pre + 1) << ex;
    bus_write(OFF_RATE, 8'((pre << 4) | ex));
    bus_write(OFF_CTRL1, 8'hD0 | {4'b0, cp, ch, 1'b0, lb});
    wait_cycles(2);
    check("R3 idle level", 32'(sck), 32'(cp));
    s_cpha = ch; s_lsb = lb; s_reply = rp; s_cap = '0; edge_n = 0;
    if (!ch) miso = rp[ord(0, lb)];
    s_on = 1'b1;
    bus_write(OFF_DATA, tx);
    cnt = 0;
    if (collide) bus_write(OFF_DATA, ~tx);
    while (!irq_xfer && cnt < 40000) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    check("R5 irq_xfer raised", 32'(irq_xfer), 32'd1);
    if (!collide) check("R4 completion time", 32'(cnt), 32'(16 * half + 1));
    wait_cycles(1);
    s_on = 1'b0;
    check("R3 edge count", 32'(edge_n), 32'd16);
    check("R2 mosi byte", 32'(s_cap), 32'(tx));
    bus_read(OFF_STAT, d);
    check(collide ? "R7 status" : "R5 status", 32'(d), collide ? 32'hC0 : 32'h80);
    bus_read(OFF_DATA, d);
    check("R2 received byte", 32'(d), 32'(rp));
    bus_read(OFF_STAT, d);
    check("R6 flags cleared", 32'(d), 32'h00);
    check("R6 irq cleared", 32'(irq_xfer), 32'd0);
  endtask

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    wait_cycles(3);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(1);

    // R1 reset state
    bus_read(OFF_CTRL1, d); check("R1 ctrl1", 32'(d), 32'h00);
    bus_read(OFF_STAT, d);  check("R1 status", 32'(d), 32'h00);
    bus_read(OFF_DATA, d);  check("R1 data", 32'(d), 32'h00);
    check("R1 sck", 32'(sck), 32'd0);
    check("R1 ss_n", 32'(ss_n), 32'd1);
    check("R1 irqs", 32'({irq_xfer, irq_modf}), 32'd0);

    // R12 readback and masks
    bus_write(OFF_CTRL2, 8'h5A); bus_read(OFF_CTRL2, d); check("R12 ctrl2", 32'(d), 32'h5A);
    bus_write(OFF_RATE, 8'hFF);  bus_read(OFF_RATE, d);  check("R4 rate mask", 32'(d), 32'h77);
    bus_write(OFF_CTRL1, 8'hFF); bus_read(OFF_CTRL1, d); check("R12 ctrl1 bit5", 32'(d), 32'hDF);
    bus_write(OFF_CTRL1, 8'h00);

    // R10 slave-select pin
    bus_write(OFF_PDIR, 8'h08); bus_read(OFF_PDIR, d); check("R12 pdir", 32'(d), 32'h08);
    bus_write(OFF_PDAT, 8'h00); wait_cycles(1); check("R10 ss low", 32'(ss_n), 32'd0);
    bus_write(OFF_PDAT, 8'h08); wait_cycles(1); check("R10 ss high", 32'(ss_n), 32'd1);
    bus_write(OFF_PDIR, 8'h00); bus_write(OFF_PDAT, 8'h00); wait_cycles(1);
    check("R10 ss released", 32'(ss_n), 32'd1);
    bus_write(OFF_PDIR, 8'h08);

    // R2 R3 all modes at two rates
    for (int m = 0; m < 8; m++) begin
      do_xfer(m[2], m[1], m[0], 0, 0, 8'(8'hA5 ^ (m * 37)), 8'(8'h3C + m * 29), 1'b0);
      do_xfer(m[2], m[1], m[0], 2, 1, 8'(8'h19 + m * 53), 8'(~(m * 71)), 1'b0);
    end
    // R4 exponent sweep and prescaler sweep
    for (int e = 0; e < 8; e++) do_xfer(1'b0, 1'b0, 1'b0, 0, e, 8'(e * 33 + 1), 8'(8'hF0 ^ e), 1'b0);
    for (int p = 0; p < 8; p++) do_xfer(1'b1, 1'b1, 1'b0, p, 2, 8'(p * 17 + 6), 8'(8'h81 + p), 1'b0);

    // R6 data read without prior status read keeps flag
    bus_write(OFF_RATE, 8'h00);
    bus_write(OFF_CTRL1, 8'hD0);
    bus_write(OFF_DATA, 8'h42);
    wait_cycles(40);
    check("R5 done flag", 32'(irq_xfer), 32'd1);
    bus_read(OFF_DATA, d);
    wait_cycles(1);
    check("R6 no clear without status read", 32'(irq_xfer), 32'd1);
    bus_read(OFF_STAT, d); check("R6 status set", 32'(d), 32'h80);
    bus_read(OFF_DATA, d); wait_cycles(1);
    check("R6 cleared after sequence", 32'(irq_xfer), 32'd0);

    // R7 collision
    do_xfer(1'b0, 1'b1, 1'b1, 1, 1, 8'h3C, 8'hC3, 1'b1);

    // R11 disable mid-exchange
    bus_write(OFF_RATE, 8'h33);
    bus_write(OFF_CTRL1, 8'hD0);
    bus_write(OFF_DATA, 8'h77);
    bus_write(OFF_DATA, 8'h11);
    wait_cycles(40);
    bus_write(OFF_CTRL1, 8'h90);
    wait_cycles(2);
    check("R11 sck idle", 32'(sck), 32'd0);
    bus_read(OFF_STAT, d); check("R11 flags cleared", 32'(d), 32'h00);
    wait_cycles(600);
    check("R11 no completion", 32'(irq_xfer), 32'd0);

    // R8 mode fault
    bus_write(OFF_RATE, 8'h00);
    bus_write(OFF_PDIR, 8'h00);
    bus_write(OFF_CTRL1, 8'hD0);
    ss_in_n = 1'b0;
    wait_cycles(3);
    check("R8 irq_modf", 32'(irq_modf), 32'd1);
    ss_in_n = 1'b1;
    bus_read(OFF_CTRL1, d); check("R8 master cleared", 32'(d), 32'hC0);
    bus_write(OFF_DATA, 8'h55);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      wait_cycles(1);
      if (sck !== 1'b0) cnt++;
    end
    check("R8 no exchange", 32'(cnt), 32'd0);
    check("R8 no completion", 32'(irq_xfer), 32'd0);

    // R9 fault clearing
    bus_write(OFF_CTRL1, 8'hD0);
    wait_cycles(1);
    check("R9 not cleared without status read", 32'(irq_modf), 32'd1);
    bus_read(OFF_STAT, d); check("R9 status fault", 32'(d), 32'h10);
    bus_write(OFF_CTRL1, 8'hD0);
    wait_cycles(1);
    check("R9 irq cleared", 32'(irq_modf), 32'd0);
    bus_read(OFF_STAT, d);  check("R9 status clear", 32'(d), 32'h00);
    bus_read(OFF_CTRL1, d); check("R9 master restored", 32'(d), 32'hD0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule